// File: doc/BRIEF.md
# Load Data Extraction and Extension Unit

This block sits after the data memory read port of a processor load pipeline. It receives one naturally aligned 64-bit read beat, the three low bits of the byte address and a load opcode. From these it picks the operand out of the beat (little-endian: the byte at the lowest address lands in the least significant byte of the result) and shapes it into a destination register value. The supported shapes are signed and unsigned byte and halfword loads, word and doubleword loads, byte-to-halfword unpacking into a 32-bit or 64-bit destination, and a halfword shift-in load that pushes 16 new bits into the top of a 64-bit register pair while the previous contents move down by 16 bits.

The unit also checks natural alignment of each access and raises a fault instead of writing when the address is misaligned for the access size. Results appear one clock after the request together with a valid flag and a two-bit write mask: bit 0 enables the low 32-bit destination register, bit 1 the high one.

Top module: `load_align_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid, out_we and out_fault are all 0.
- R2: out_valid equals in_valid of the previous cycle; in a cycle after in_valid was low, out_we and out_fault are 0.
- R3: Opcodes 0 (unsigned byte) and 1 (signed byte) take byte number in_addr_lo of the beat into result bits 7:0, fill bits 31:8 with zeros (0) or with bit 7 of that byte (1), drive bits 63:32 to zero, set out_we to 01 and never fault.
- R4: Opcodes 2 (unsigned halfword) and 3 (signed halfword) take bytes in_addr_lo and in_addr_lo+1 as bits 7:0 and 15:8, fill bits 31:16 with zeros or with bit 15, drive bits 63:32 to zero and set out_we to 01.
- R5: Opcode 4 (word) takes the four bytes from in_addr_lo upward into bits 31:0, drives bits 63:32 to zero and sets out_we to 01.
- R6: Opcode 5 (doubleword) passes the whole beat through and sets out_we to 11.
- R7: Opcodes 6 (unsigned) and 7 (signed) unpack two bytes from in_addr_lo upward into result bytes 0 and 2; bytes 1 and 3 are zero or copies of bit 7 of the byte just below; bits 63:32 are zero; out_we is 01.
- R8: Opcodes 8 (unsigned) and 9 (signed) unpack four bytes from in_addr_lo upward into result bytes 0, 2, 4 and 6; bytes 1, 3, 5 and 7 are zero or sign copies of the byte below; out_we is 11.
- R9: Opcode 10 (halfword shift-in) places the halfword at in_addr_lo in result bits 63:48 and in_old bits 63:16 in result bits 47:0; out_we is 11.
- R10: out_fault is 1 for opcodes 2, 3, 6, 7, 10 when address bit 0 is 1; for opcodes 4, 8, 9 when address bits 1:0 are nonzero; for opcode 5 when address bits 2:0 are nonzero; never for opcodes 0 and 1.
- R11: Whenever out_fault is 1, out_we is 00.
- R12: Opcodes 11 to 15 are unassigned: out_valid still follows in_valid, but out_we is 00 and out_fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Load opcode (see requirements) |
| in_addr_lo | input | 3 | Byte address bits 2:0 |
| in_beat | input | 64 | 8-byte aligned read data |
| in_old | input | 64 | Current destination pair, used by the shift-in load |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Shaped destination value |
| out_we | output | 2 | Write mask: bit 0 low register, bit 1 high register |
| out_fault | output | 1 | Misaligned access, no write performed |

## Verification
The assertions take for granted that in_op, in_addr_lo and in_old are stable and meaningful in every cycle where in_valid is high, and that reset is held for at least one clock edge before requests arrive. The stimulus drives all inputs only on the falling edge and sweeps every opcode, including the unassigned ones, over every address offset with beats chosen to set and clear the sign bits, so both aligned and misaligned cases of each size are reached. Idle cycles are inserted between bursts so that the quiet-output rule is exercised after real traffic.

// File: rtl/ldx_pkg.sv
// Package: shared opcode encoding and widths for the load extraction unit.
// Assumes a 4-bit opcode field; codes above LD_HSHIFT are unassigned.
package ldx_pkg;
    parameter int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        LD_BYTE_U  = 4'd0,
        LD_BYTE_S  = 4'd1,
        LD_HALF_U  = 4'd2,
        LD_HALF_S  = 4'd3,
        LD_WORD    = 4'd4,
        LD_DWORD   = 4'd5,
        LD_UNPK2_U = 4'd6,
        LD_UNPK2_S = 4'd7,
        LD_UNPK4_U = 4'd8,
        LD_UNPK4_S = 4'd9,
        LD_HSHIFT  = 4'd10
    } ld_op_e;
endpackage

// File: rtl/ldx_lane_select.sv
// Module: moves the addressed byte lane of an aligned beat down to bit 0.
// Assumes a little-endian beat; bytes above the operand are don't-care.
module ldx_lane_select #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] beat,
    input  logic [ADDR_W-1:0] addr_lo,
    output logic [DATA_W-1:0] field
);
    localparam int SH_W = ADDR_W + 3;

    logic [SH_W-1:0] bit_shift;

    // Convert byte offset into a bit shift and align the operand.
    always_comb begin
        bit_shift = {addr_lo, 3'b000};
        field     = beat >> bit_shift;
    end
endmodule

// File: rtl/ldx_align_check.sv
// Module: decides access size per opcode and flags natural misalignment.
// Assumes unassigned opcodes have no size and so never fault.
module ldx_align_check
    import ldx_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  ld_op_e            op,
    input  logic [ADDR_W-1:0] addr_lo,
    output logic              fault
);
    logic [ADDR_W-1:0] size_mask;

    // Mask of address bits that must be zero for this access size.
    always_comb begin
        unique case (op)
            LD_HALF_U, LD_HALF_S, LD_UNPK2_U, LD_UNPK2_S, LD_HSHIFT:
                size_mask = ADDR_W'(1);
            LD_WORD, LD_UNPK4_U, LD_UNPK4_S:
                size_mask = ADDR_W'(3);
            LD_DWORD:
                size_mask = ADDR_W'(7);
            default:
                size_mask = '0;
        endcase
        fault = |(addr_lo & size_mask);
    end
endmodule

// File: rtl/ldx_extend.sv
// Module: shapes an aligned operand into the destination value per opcode.
// Assumes field holds the operand at bit 0; old is the prior destination pair.
module ldx_extend
    import ldx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  ld_op_e            op,
    input  logic [DATA_W-1:0] field,
    input  logic [DATA_W-1:0] old,
    output logic [DATA_W-1:0] result,
    output logic              wide,
    output logic              known
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int N_LANES = DATA_W / 16;

    logic                unpk_signed;
    logic [N_LANES-1:0][15:0] unpk_half;
    logic [HALF_W-1:0]   unused_old_lo;

    assign unpk_signed   = (op == LD_UNPK2_S) || (op == LD_UNPK4_S);
    assign unused_old_lo = old[HALF_W-1:0];

    // One unpacked halfword lane per source byte.
    genvar i;
    generate
        for (i = 0; i < N_LANES; i++) begin : g_unpk
            assign unpk_half[i] = {unpk_signed ? {8{field[8*i+7]}} : 8'h00,
                                   field[8*i +: 8]};
        end
    endgenerate

    // Select the shaped value and destination width for the opcode.
    always_comb begin
        result = '0;
        wide   = 1'b0;
        known  = 1'b1;
        unique case (op)
            LD_BYTE_U:  result[HALF_W-1:0] = {{(HALF_W-8){1'b0}}, field[7:0]};
            LD_BYTE_S:  result[HALF_W-1:0] = {{(HALF_W-8){field[7]}}, field[7:0]};
            LD_HALF_U:  result[HALF_W-1:0] = {{(HALF_W-16){1'b0}}, field[15:0]};
            LD_HALF_S:  result[HALF_W-1:0] = {{(HALF_W-16){field[15]}}, field[15:0]};
            LD_WORD:    result[HALF_W-1:0] = field[HALF_W-1:0];
            LD_DWORD: begin
                result = field;
                wide   = 1'b1;
            end
            LD_UNPK2_U, LD_UNPK2_S:
                result[31:0] = {unpk_half[1], unpk_half[0]};
            LD_UNPK4_U, LD_UNPK4_S: begin
                result = unpk_half;
                wide   = 1'b1;
            end
            LD_HSHIFT: begin
                result = {field[15:0], old[DATA_W-1:16]};
                wide   = 1'b1;
            end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/load_align_unit.sv
// Module: top of the load extraction unit; registers the shaped result,
// write mask and alignment fault one cycle after a valid request.
// Assumes inputs are meaningful only while in_valid is high.
module load_align_unit
    import ldx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [2:0]        in_addr_lo,
    input  logic [63:0]       in_beat,
    input  logic [63:0]       in_old,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic [1:0]        out_we,
    output logic              out_fault
);
    localparam int ADDR_W = $clog2(DATA_W / 8);

    ld_op_e            op;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] shaped;
    logic              is_wide;
    logic              is_known;
    logic              misaligned;
    logic [1:0]        we_next;

    assign op = ld_op_e'(in_op);

    ldx_lane_select #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lane (
        .beat    (in_beat),
        .addr_lo (in_addr_lo),
        .field   (field)
    );

    ldx_align_check #(.ADDR_W(ADDR_W)) u_align (
        .op      (op),
        .addr_lo (in_addr_lo),
        .fault   (misaligned)
    );

    ldx_extend #(.DATA_W(DATA_W)) u_ext (
        .op     (op),
        .field  (field),
        .old    (in_old),
        .result (shaped),
        .wide   (is_wide),
        .known  (is_known)
    );

    // Write mask: suppressed on fault or unassigned opcode.
    always_comb begin
        if (misaligned || !is_known) we_next = 2'b00;
        else if (is_wide)            we_next = 2'b11;
        else                         we_next = 2'b01;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_we    <= 2'b00;
            out_fault <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data  <= shaped;
                out_we    <= we_next;
                out_fault <= misaligned;
            end else begin
                out_we    <= 2'b00;
                out_fault <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ldx_checker.sv
// Module: property checker for load_align_unit, attached by bind.
// Assumes inputs are stable across the sampling edge when in_valid is high.
module ldx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_op,
    input logic [2:0]  in_addr_lo,
    input logic [63:0] in_old,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic [1:0]  out_we,
    input logic        out_fault
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (out_we == 2'b00 && !out_fault)); // R2

    AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 4'd1) |=> !out_fault); // R3

    AST_WORD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd4 && in_addr_lo[1:0] == 2'b00)
        |=> (out_we == 2'b01 && out_data[63:32] == 32'h0)); // R5

    AST_SHIFT_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd10 && !in_addr_lo[0])
        |=> (out_data[47:0] == $past(in_old[63:16]))); // R9

    AST_DWORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd5 && in_addr_lo != 3'd0) |=> out_fault); // R10

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_we == 2'b00); // R11

    AST_UNASSIGNED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd11) |=> (out_we == 2'b00 && !out_fault)); // R12
endmodule

bind load_align_unit ldx_checker u_ldx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_addr_lo (in_addr_lo),
    .in_old     (in_old),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_we     (out_we),
    .out_fault  (out_fault)
);

// File: tb/load_align_unit_test.sv
`timescale 1ns/1ps
module load_align_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [2:0]  in_addr_lo = '0;
    logic [63:0] in_beat = '0;
    logic [63:0] in_old = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [1:0]  out_we;
    logic        out_fault;

    typedef struct {
        logic [63:0] data;
        logic [1:0]  we;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    always #2.5 clk = ~clk;

    load_align_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_addr_lo(in_addr_lo), .in_beat(in_beat), .in_old(in_old),
        .out_valid(out_valid), .out_data(out_data), .out_we(out_we),
        .out_fault(out_fault)
    );

    // Reference model built from the requirement text.
    function automatic exp_t model(input logic [3:0] op, input logic [2:0] a,
                                   input logic [63:0] beat, input logic [63:0] old);
        exp_t e;
        logic [7:0] b [8];
        int size;
        int ai;
        for (int k = 0; k < 8; k++) b[k] = beat[8*k +: 8];
        ai = int'(a);
        e.data = '0; e.we = 2'b01; e.fault = 0;
        case (op)
            0, 1:    begin size = 1; e.tag = "R3"; end
            2, 3:    begin size = 2; e.tag = "R4"; end
            4:       begin size = 4; e.tag = "R5"; end
            5:       begin size = 8; e.tag = "R6"; end
            6, 7:    begin size = 2; e.tag = "R7"; end
            8, 9:    begin size = 4; e.tag = "R8"; end
            10:      begin size = 2; e.tag = "R9"; end
            default: begin size = 0; e.tag = "R12"; end
        endcase
        if (size == 0) begin
            e.we = 2'b00;
            return e;
        end
        if (ai % size != 0) begin
            e.fault = 1; e.we = 2'b00; e.tag = "R10/R11";
            return e;
        end
        case (op)
            0, 1: begin
                e.data[7:0] = b[ai];
                for (int k = 8; k < 32; k++) e.data[k] = (op == 1) ? b[ai][7] : 1'b0;
            end
            2, 3: begin
                e.data[15:0] = {b[ai+1], b[ai]};
                for (int k = 16; k < 32; k++) e.data[k] = (op == 3) ? b[ai+1][7] : 1'b0;
            end
            4: for (int k = 0; k < 4; k++) e.data[8*k +: 8] = b[ai+k];
            5: begin e.data = beat; e.we = 2'b11; end
            6, 7, 8, 9: begin
                for (int k = 0; k < size; k++) begin
                    e.data[16*k +: 8]   = b[ai+k];
                    e.data[16*k+8 +: 8] = (op == 7 || op == 9) ? {8{b[ai+k][7]}} : 8'h00;
                end
                if (size == 4) e.we = 2'b11;
            end
            default: begin
                e.data = {b[ai+1], b[ai], old[63:16]};
                e.we = 2'b11;
            end
        endcase
        return e;
    endfunction

    // Driver: present one request at the falling edge and queue its expectation.
    task automatic drive(input logic [3:0] op, input logic [2:0] a,
                         input logic [63:0] beat, input logic [63:0] old);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr_lo = a; in_beat = beat; in_old = old;
        exp_q.push_back(model(op, a, beat, old));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op = 4'd5; in_addr_lo = 3'd3; in_beat = '1;
        end
    endtask

    // Monitor: compare each valid result with the oldest expectation.
    initial begin
        exp_t e;
        logic prev_valid;
        prev_valid = 0;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (out_valid) begin
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fails++;
                        $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
                    end else begin
                        e = exp_q.pop_front();
                        if (out_we !== e.we || out_fault !== e.fault ||
                            (e.we != 2'b00 && out_data !== e.data)) begin
                            n_fails++;
                            $display("FAIL %s data=%h exp=%h we=%b exp=%b fault=%b exp=%b",
                                     e.tag, out_data, e.data, out_we, e.we, out_fault, e.fault);
                        end
                    end
                end else if (prev_valid) begin
                    n_checks++;
                    if (exp_q.size() != 0) begin
                        n_fails++;
                        $display("FAIL R2 missing out_valid: actual 0 expected 1");
                    end
                    if (out_we !== 2'b00 || out_fault !== 1'b0) begin
                        n_fails++;
                        $display("FAIL R2 idle outputs: we=%b fault=%b expected 00 0",
                                 out_we, out_fault);
                    end
                end
                prev_valid = out_valid;
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] beats [4];
        beats[0] = 64'h8877_6655_4433_2211;
        beats[1] = 64'hF1E2_D3C4_B5A6_9788;
        beats[2] = 64'h7F80_017E_FF00_80FE;
        beats[3] = {$urandom, $urandom};

        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        n_checks++;
        if (out_valid !== 1'b0 || out_we !== 2'b00 || out_fault !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset: valid=%b we=%b fault=%b expected 0 00 0",
                     out_valid, out_we, out_fault);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_we !== 2'b00 || out_fault !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 after reset: valid=%b we=%b fault=%b expected 0 00 0",
                     out_valid, out_we, out_fault);
        end

        for (int bi = 0; bi < 4; bi++) begin
            for (int op = 0; op < 16; op++) begin
                for (int a = 0; a < 8; a++) begin
                    drive(4'(op), 3'(a), beats[bi], ~beats[bi] ^ {$urandom, $urandom});
                end
                if (op % 5 == 4) idle(2);
            end
        end
        // Fault directly followed by good request and an idle gap (R10, R11, R2)
        drive(4'd4, 3'd2, beats[0], '0);
        drive(4'd4, 3'd4, beats[0], '0);
        idle(3);
        drive(4'd10, 3'd6, beats[1], 64'hDEAD_BEEF_0123_4567);
        drive(4'd10, 3'd6, beats[2], 64'hDEAD_BEEF_0123_4567);
        idle(4);

        done = 1;
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 leftover expectations: actual %0d expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule